// File: doc/BRIEF.md
# Serial Memory Status and Write-Protect Controller

This block keeps the status register of a serial memory slave and decides whether each requested write may go ahead. A command parser in front of it decodes the serial instructions and presents them as single-cycle strobes. These strobes are enable-writes, disable-writes, load-status, data-write start and write-cycle done. The parser also presents the target memory address. The block answers with the status byte for read-status commands, a permit flag for a data write at the presented address, and a permit flag for a status load.

A write must pass three gates. The first is the write-enable latch. The second is a protected region at the top of the array, sized by three block-protect bits. The third is a hardware protect pin, active low, that blocks status loads only when the protect-enable bit in the same register is set. While an internal write cycle runs, the block reports busy and refuses everything except enable-writes. The nonvolatile fields are modelled as ordinary flops.

Top module: `spi_wp_ctrl`

## Requirements
- R1: Status bit 0 (busy) becomes 1 in the cycle after an accepted data-write start or an accepted status load. It returns to 0 in the cycle after `cyc_done_i`. Status-load data never changes bit 0 or bit 1.
- R2: Status bit 1 (write-enable latch) is set by `wr_en_i`, which the parser raises for opcode 0x06. It is cleared by `wr_dis_i`, which the parser raises for opcode 0x04. When `wr_en_i` arrives in the same cycle as either clearing event, `wr_en_i` wins.
- R3: The block-protect value P sits in status bits 4:2 and is loaded from bits 4:2 of `sr_data_i`. P=0 protects nothing. For P>0, the protected region is the top min(2^(P-1), pages/2) pages of the array. The array holds 2^ADDR_W bytes and a page holds 2^PAGE_W bytes.
- R4: `wr_permit_o` is 1 exactly when the latch is 1, busy is 0 and `addr_i` lies outside the protected region. Reads are never gated.
- R5: While `wp_n_i` is 0 and the protect-enable bit (status bit 7) is 1, `sr_permit_o` is 0 and a status load leaves the whole status byte unchanged.
- R6: While the protect-enable bit is 0, `wp_n_i` has no effect on `sr_permit_o` or on status loads.
- R7: While the latch is 0, neither permit flag is 1. A data-write start or status load in that state changes nothing.
- R8: `cyc_done_i` during a write cycle clears both busy and the latch in the following cycle.
- R9: While busy is 1, disable-writes, status loads and data-write starts are ignored. Only `wr_en_i` takes effect.
- R10: After reset the status byte is 0x00. Status bits 6:5 always read 0. Bit 7 is loaded from bit 7 of `sr_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en_i | input | 1 | Enable-writes strobe (opcode 0x06) |
| wr_dis_i | input | 1 | Disable-writes strobe (opcode 0x04) |
| sr_load_i | input | 1 | Status-load strobe |
| sr_data_i | input | 8 | Data byte of the status load |
| cyc_start_i | input | 1 | Data-write start strobe for `addr_i` |
| cyc_done_i | input | 1 | Internal write cycle finished |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| addr_i | input | ADDR_W | Memory address of the pending request |
| status_o | output | 8 | Status byte |
| wr_permit_o | output | 1 | Data write at `addr_i` allowed |
| sr_permit_o | output | 1 | Status load allowed |

## Verification
The hardest case to reach is a refused status load under the hardware protect. It needs the protect-enable bit already set, which can only happen through an earlier permitted load and its completed write cycle. After that, the enable latch must be raised again and the pin pulled low before the load is issued. The bench builds that history step by step. Around it, the bench sweeps every block-protect value against every address of a 256-byte, 16-page configuration.

// File: rtl/spi_wp_pkg.sv
// Shared types for the status and write-protect controller.
// Assumes an 8-bit status byte with the field layout below.
package spi_wp_pkg;
    localparam int BP_W = 3;

    typedef struct packed {
        logic            wpen;   // bit 7: hardware-protect enable
        logic [1:0]      zero;   // bits 6:5: always 0
        logic [BP_W-1:0] bp;     // bits 4:2: block-protect value
        logic            wel;    // bit 1: write-enable latch
        logic            busy;   // bit 0: write cycle in progress
    } status_t;
endpackage

// File: rtl/spi_wp_latch.sv
// Busy flag and write-enable latch sequencing.
// Assumes the go strobes are already qualified (permitted) by the caller.
module spi_wp_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_dis,
    input  logic data_go,
    input  logic sr_go,
    input  logic done,
    output logic busy,
    output logic wel
);
    // Busy: set by an accepted write, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                busy <= 1'b0;
        else if (done)             busy <= 1'b0;
        else if (data_go || sr_go) busy <= 1'b1;
    end

    // Latch: enable wins; completion or an idle disable clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wel <= 1'b0;
        else if (wr_en)             wel <= 1'b1;
        else if (done && busy)      wel <= 1'b0;
        else if (wr_dis && !busy)   wel <= 1'b0;
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R1
    AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wel); // R2
    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && done && !wr_en |=> !busy && !wel); // R8
    AST_BUSY_NO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wel && !done |=> wel); // R9
endmodule

// File: rtl/spi_wp_stat_regs.sv
// Block-protect and protect-enable fields, loaded by a permitted status write.
// Assumes load is already qualified; other data bits are discarded.
module spi_wp_stat_regs
    import spi_wp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [7:0]      data,
    output logic [BP_W-1:0] bp,
    output logic            wpen
);
    // Capture bits 4:2 and bit 7 of the status data on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp   <= '0;
            wpen <= 1'b0;
        end else if (load) begin
            bp   <= data[2 +: BP_W];
            wpen <= data[7];
        end
    end
endmodule

// File: rtl/spi_wp_region.sv
// Protected-region decode: the top min(2^(bp-1), half) pages are protected.
// Assumes ADDR_W > PAGE_W so that half the array is at least one page.
module spi_wp_region
    import spi_wp_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              prot
);
    localparam int NPG_LOG = ADDR_W - PAGE_W;
    localparam int NBP     = 1 << BP_W;

    logic [NBP-1:0] hit;

    assign hit[0] = 1'b0;
    // One top-of-array compare per non-zero protect value.
    for (genvar k = 1; k < NBP; k++) begin : g_cmp
        localparam int SZ_LOG = PAGE_W + (((k - 1) < (NPG_LOG - 1)) ? (k - 1) : (NPG_LOG - 1));
        assign hit[k] = &addr[ADDR_W-1:SZ_LOG];
    end

    // Select the compare for the current protect value.
    always_comb begin
        prot = hit[bp];
    end
endmodule

// File: rtl/spi_wp_ctrl.sv
// Status register and write-protect controller for a serial memory slave.
// Assumes one-cycle decoded instruction strobes from a command parser.
module spi_wp_ctrl
    import spi_wp_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              wr_dis_i,
    input  logic              sr_load_i,
    input  logic [7:0]        sr_data_i,
    input  logic              cyc_start_i,
    input  logic              cyc_done_i,
    input  logic              wp_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              wr_permit_o,
    output logic              sr_permit_o
);
    logic            busy, wel, wpen, addr_prot, hw_lock;
    logic [BP_W-1:0] bp;
    status_t         st;

    // Permit decisions from latch, busy, region and pin.
    always_comb begin
        hw_lock     = !wp_n_i && wpen;
        wr_permit_o = wel && !busy && !addr_prot;
        sr_permit_o = wel && !busy && !hw_lock;
    end

    spi_wp_latch u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_dis  (wr_dis_i),
        .data_go (cyc_start_i && wr_permit_o),
        .sr_go   (sr_load_i && sr_permit_o),
        .done    (cyc_done_i),
        .busy    (busy),
        .wel     (wel)
    );

    spi_wp_stat_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sr_load_i && sr_permit_o),
        .data  (sr_data_i),
        .bp    (bp),
        .wpen  (wpen)
    );

    spi_wp_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .bp   (bp),
        .addr (addr_i),
        .prot (addr_prot)
    );

    // Assemble the status byte.
    always_comb begin
        st.wpen  = wpen;
        st.zero  = 2'b00;
        st.bp    = bp;
        st.wel   = wel;
        st.busy  = busy;
        status_o = st;
    end

    AST_HWP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        hw_lock |=> $stable(status_o[7:2])); // R5
    AST_NO_WEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wel |-> !wr_permit_o && !sr_permit_o); // R7
    AST_PROT_UPPER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        addr_prot |-> addr_i[ADDR_W-1]); // R3
    AST_BP_ZERO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        bp == '0 |-> !addr_prot); // R3
    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !cyc_done_i |=> $stable(status_o[7:2])); // R9
endmodule

// File: tb/spi_wp_ctrl_tb.sv
module spi_wp_ctrl_tb;
    localparam int AW = 8;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 0, wr_dis = 0, sr_load = 0, cstart = 0, cdone = 0, wp_n = 1;
    logic [7:0]    sr_data = 0;
    logic [AW-1:0] addr = 0;
    logic [7:0]    status;
    logic          wr_permit, sr_permit;
    int            checks = 0, errors = 0;
    bit            finished = 0;

    always #5 clk = ~clk;

    spi_wp_ctrl #(.ADDR_W(AW), .PAGE_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_dis_i(wr_dis),
        .sr_load_i(sr_load), .sr_data_i(sr_data), .cyc_start_i(cstart),
        .cyc_done_i(cdone), .wp_n_i(wp_n), .addr_i(addr),
        .status_o(status), .wr_permit_o(wr_permit), .sr_permit_o(sr_permit)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One-cycle strobe: bit0 wr_en, bit1 wr_dis, bit2 sr_load, bit3 start, bit4 done.
    task automatic pulse(input logic [4:0] s);
        @(negedge clk);
        {cdone, cstart, sr_load, wr_dis, wr_en} = s;
        @(negedge clk);
        {cdone, cstart, sr_load, wr_dis, wr_en} = '0;
        #1;
    endtask

    function automatic bit prot_exp(input int bp, input int a);
        int pages;
        if (bp == 0) return 0;
        pages = 1 << (bp - 1);
        if (pages > 8) pages = 8;
        return a >= 256 - pages * 16;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R10 reset status", status, 8'h00);
        chk("R7 reset wr_permit", wr_permit, 0);
        chk("R7 reset sr_permit", sr_permit, 0);

        // R3/R4 sweep over every protect value and address
        for (int bp = 0; bp < 8; bp++) begin
            pulse(5'b00001);
            sr_data = 8'(bp << 2);
            pulse(5'b00100);
            chk("R1 busy after load", status[0], 1);
            pulse(5'b10000);
            pulse(5'b00001);
            chk("R3 status after load", status, (bp << 2) | 2);
            for (int a = 0; a < 256; a++) begin
                @(negedge clk);
                addr = 8'(a);
                #1;
                chk("R4 wr_permit sweep", wr_permit, !prot_exp(bp, a));
            end
        end
        // bp=7 now, latch set; R1/R10 load 0xFF
        addr = 0;
        sr_data = 8'hFF;
        pulse(5'b00100);
        chk("R10 load 0xFF", status, 8'h9F);
        pulse(5'b10000);
        chk("R8 done clears", status, 8'h9C);
        // R6 path later; first hardware lock (wpen=1)
        pulse(5'b00001);
        wp_n = 0;
        #1;
        chk("R5 sr_permit locked", sr_permit, 0);
        sr_data = 8'h00;
        pulse(5'b00100);
        chk("R5 load refused", status, 8'h9E);
        wp_n = 1;
        #1;
        chk("R5 pin high permits", sr_permit, 1);
        pulse(5'b00100);
        pulse(5'b10000);
        chk("R5 load after release", status, 8'h00);
        // R6: wpen 0, pin low ignored
        pulse(5'b00001);
        wp_n = 0;
        #1;
        chk("R6 sr_permit pin ignored", sr_permit, 1);
        sr_data = 8'h0F;
        pulse(5'b00100);
        chk("R6 load accepted", status, 8'h0F);
        pulse(5'b10000);
        chk("R8 done", status, 8'h0C);
        wp_n = 1;
        // R7: latch 0
        pulse(5'b01000);
        chk("R7 start refused", status, 8'h0C);
        sr_data = 8'h00;
        pulse(5'b00100);
        chk("R7 load refused", status, 8'h0C);
        // R9: busy refuses
        pulse(5'b00001);
        pulse(5'b01000);
        chk("R1 start sets busy", status, 8'h0F);
        pulse(5'b00010);
        chk("R9 disable ignored", status, 8'h0F);
        pulse(5'b00100);
        chk("R9 load ignored", status, 8'h0F);
        chk("R9 wr_permit busy", wr_permit, 0);
        pulse(5'b10001);
        chk("R2 enable wins over done", status, 8'h0E);
        pulse(5'b00010);
        chk("R2 disable clears", status, 8'h0C);
        pulse(5'b00011);
        chk("R2 enable wins over disable", status, 8'h0E);
        finished = 1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
        end
    end

    initial begin
        wait (finished || errors > 0 && checks > 99999);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100001) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule